// File: doc/BRIEF.md
# Capacitor Trim Offset Combiner

This block produces the code that selects how many unit capacitors a crystal-trim array switches in. A compensation engine delivers a temperature-derived code with a one-cycle done strobe and the temperature it used. The block adds a software-programmed signed correction (one step per unit capacitor) to that code, clamps the sum to the legal code window, and holds the result on its output until the next accepted conversion.

A result is accepted only when a conversion is new: either the reported temperature differs from the one stored at the last accepted conversion, or a manual conversion was requested. Writing a new correction therefore has no visible effect until the next accepted conversion. A manual request stays pending, with the busy output high, until the conversion it triggered has reached the output, and then clears by itself.

The controller has four states. IDLE waits for a strobe. WAIT holds a pending manual request until the next strobe. SUM registers the clamped sum. APPLY copies it to the output. The transitions are: IDLE to SUM on an accepted strobe, IDLE to WAIT when a request is pending and no accepted strobe arrives, WAIT to SUM on any strobe, SUM to APPLY always, and APPLY to IDLE always.

Top module: `cap_trim_combiner`

## Requirements
- R1: After reset the trim output equals TRIM_RST, busy is low, no request is pending, and the stored correction is 0, so the first accepted conversion passes the engine code through unchanged.
- R2: An accepted conversion sets the trim output to the engine code plus the correction byte. The byte is read as two's complement, with bit 7 as the sign. Positive values raise the code and negative values lower it.
- R3: The sum is clamped to CODE_MIN when it falls below it and to CODE_MAX when it rises above it. It never wraps.
- R4: A write of the correction byte leaves the trim output unchanged until a later accepted conversion.
- R5: A strobe in IDLE is accepted when the temperature differs from the last accepted one. The new trim value appears on the third rising clock edge counted from the edge that samples the strobe. Busy is high in between.
- R6: The first strobe after reset is always accepted. A later strobe in IDLE with no request pending and the same temperature as the last accepted one is dropped: the trim output stays as it was and busy stays low.
- R7: A one-cycle manual request raises busy and stays pending. The next strobe is accepted whatever its temperature. The request clears itself once that result has reached the output, and busy then falls.
- R8: Busy is high whenever the controller is outside IDLE or a manual request is pending.
- R9: A strobe that arrives while SUM or APPLY is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_code | input | CODE_W | Temperature-derived trim code from the compensation engine |
| eng_done | input | 1 | One-cycle strobe: eng_code and eng_temp are valid |
| eng_temp | input | TEMP_W | Temperature used for this conversion |
| manual_req | input | 1 | One-cycle request to force the next conversion through |
| ofs_wr_en | input | 1 | Write strobe for the correction byte |
| ofs_wr_data | input | 8 | Signed correction, two's complement |
| trim_code | output | CODE_W | Registered code for the capacitor array |
| conv_busy | output | 1 | High while a conversion is pending or in progress |

## Verification
The bench builds the block with a 6-bit code, a window of 2 to 60, a reset value of 32 and a 4-bit temperature. With these values every engine code can be run against every one of the 256 correction bytes in a single run, about sixteen thousand conversions. The sweep reaches both clamp limits many times, covers the whole negative half of the byte, and covers sums that overflow the 6-bit code width. The toggled temperature makes every sweep conversion a normal, temperature-triggered one. Directed sequences cover the first strobe after reset, a strobe with an unchanged temperature, a manual request, and a strobe that arrives while SUM is in progress.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SUM   = 2'd2,
        ST_APPLY = 2'd3
    } trim_state_t;

endpackage

// File: rtl/trim_offset_reg.sv
module trim_offset_reg #(
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_data,
    output logic [OFS_W-1:0] ofs_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (wr_en) begin
            ofs_q <= wr_data;
        end
    end

endmodule

// File: rtl/trim_temp_tracker.sv
module trim_temp_tracker #(
    parameter int unsigned TEMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TEMP_W-1:0] temp_in,
    output logic              changed
);

    logic [TEMP_W-1:0] last_q;
    logic              seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
        end else if (capture) begin
            last_q <= temp_in;
            seen_q <= 1'b1;
        end
    end

    // the first conversion after reset has nothing to compare against
    assign changed = !seen_q || (temp_in != last_q);

endmodule

// File: rtl/trim_sat_adder.sv
module trim_sat_adder #(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned OFS_W    = 8,
    parameter int unsigned CODE_MIN = 0,
    parameter int unsigned CODE_MAX = 255
) (
    input  logic [CODE_W-1:0] code,
    input  logic [OFS_W-1:0]  ofs,
    output logic [CODE_W-1:0] result
);

    localparam int unsigned SUM_W = ((CODE_W > OFS_W) ? CODE_W : OFS_W) + 2;
    localparam logic signed [SUM_W-1:0] LO = SUM_W'(CODE_MIN);
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(CODE_MAX);

    logic signed [SUM_W-1:0] code_ext;
    logic signed [SUM_W-1:0] ofs_ext;
    logic signed [SUM_W-1:0] total;

    always_comb begin
        code_ext = $signed({{(SUM_W-CODE_W){1'b0}}, code});
        ofs_ext  = $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
        total    = code_ext + ofs_ext;
        if (total < LO) begin
            result = CODE_W'(CODE_MIN);
        end else if (total > HI) begin
            result = CODE_W'(CODE_MAX);
        end else begin
            result = total[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/trim_ctrl_fsm.sv
module trim_ctrl_fsm
    import trim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eng_done,
    input  logic        temp_changed,
    input  logic        manual_req,
    output trim_state_t state_q,
    output logic        pend_q,
    output logic        capture,
    output logic        do_sum,
    output logic        do_apply
);

    trim_state_t state_d;
    logic        cap_manual_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eng_done && (temp_changed || pend_q)) begin
                    state_d = ST_SUM;
                end else if (pend_q || manual_req) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (eng_done) begin
                    state_d = ST_SUM;
                end
            end
            ST_SUM:   state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture  = 1'b0;
        do_sum   = 1'b0;
        do_apply = 1'b0;
        unique case (state_q)
            ST_IDLE:  capture  = eng_done && (temp_changed || pend_q);
            ST_WAIT:  capture  = eng_done;
            ST_SUM:   do_sum   = 1'b1;
            ST_APPLY: do_apply = 1'b1;
            default: ;
        endcase
    end

    // manual request: set on request, cleared when its own result lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            cap_manual_q <= 1'b0;
        end else begin
            if (capture) begin
                cap_manual_q <= pend_q;
            end
            if (manual_req) begin
                pend_q <= 1'b1;
            end else if (do_apply && cap_manual_q) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cap_trim_combiner.sv
module cap_trim_combiner
    import trim_pkg::*;
#(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned TEMP_W   = 10,
    parameter int unsigned CODE_MIN = 0,
    parameter int unsigned CODE_MAX = (1 << CODE_W) - 1,
    parameter int unsigned TRIM_RST = 1 << (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] eng_code,
    input  logic              eng_done,
    input  logic [TEMP_W-1:0] eng_temp,
    input  logic              manual_req,
    input  logic              ofs_wr_en,
    input  logic [7:0]        ofs_wr_data,
    output logic [CODE_W-1:0] trim_code,
    output logic              conv_busy
);

    localparam int unsigned OFS_W = 8;

    trim_state_t       state_w;
    logic              pend_w;
    logic              capture_w;
    logic              do_sum_w;
    logic              do_apply_w;
    logic              temp_changed_w;
    logic [OFS_W-1:0]  ofs_w;
    logic [CODE_W-1:0] sat_w;

    logic [CODE_W-1:0] cap_code_q;
    logic [OFS_W-1:0]  cap_ofs_q;
    logic [CODE_W-1:0] sum_q;
    logic [CODE_W-1:0] trim_q;

    trim_offset_reg #(.OFS_W(OFS_W)) u_ofs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ofs_wr_en),
        .wr_data (ofs_wr_data),
        .ofs_q   (ofs_w)
    );

    trim_temp_tracker #(.TEMP_W(TEMP_W)) u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture_w),
        .temp_in (eng_temp),
        .changed (temp_changed_w)
    );

    trim_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .eng_done     (eng_done),
        .temp_changed (temp_changed_w),
        .manual_req   (manual_req),
        .state_q      (state_w),
        .pend_q       (pend_w),
        .capture      (capture_w),
        .do_sum       (do_sum_w),
        .do_apply     (do_apply_w)
    );

    trim_sat_adder #(
        .CODE_W   (CODE_W),
        .OFS_W    (OFS_W),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX)
    ) u_add (
        .code   (cap_code_q),
        .ofs    (cap_ofs_q),
        .result (sat_w)
    );

    // datapath: capture operands, register clamped sum, then drive output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_code_q <= '0;
            cap_ofs_q  <= '0;
            sum_q      <= CODE_W'(TRIM_RST);
            trim_q     <= CODE_W'(TRIM_RST);
        end else begin
            if (capture_w) begin
                cap_code_q <= eng_code;
                cap_ofs_q  <= ofs_w;
            end
            if (do_sum_w) begin
                sum_q <= sat_w;
            end
            if (do_apply_w) begin
                trim_q <= sum_q;
            end
        end
    end

    assign trim_code = trim_q;
    assign conv_busy = (state_w != ST_IDLE) || pend_w;

endmodule

// File: rtl/trim_combiner_chk.sv
module trim_combiner_chk
    import trim_pkg::*;
#(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned TEMP_W   = 10,
    parameter int unsigned CODE_MIN = 0,
    parameter int unsigned CODE_MAX = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_done,
    input  logic [TEMP_W-1:0] eng_temp,
    input  logic [CODE_W-1:0] trim_code,
    input  logic              conv_busy,
    input  trim_state_t       state_w,
    input  logic              pend_w,
    input  logic              temp_changed_w
);

    logic temp_any;
    assign temp_any = ^eng_temp;

    assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_code >= CODE_W'(CODE_MIN)) && (trim_code <= CODE_W'(CODE_MAX)));

    assert_hold_outside_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w != ST_APPLY) |=> $stable(trim_code));

    assert_accept_new_temp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE && eng_done && temp_changed_w) |=> (state_w == ST_SUM));

    assert_drop_same_temp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE && eng_done && !temp_changed_w && !pend_w && (temp_any || !temp_any))
        |=> (state_w != ST_SUM));

    assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_w) |-> ($past(state_w) == ST_APPLY));

    assert_busy_outside_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w != ST_IDLE) |-> conv_busy);

    assert_sum_not_interrupted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_SUM) |=> (state_w == ST_APPLY));

    assert_apply_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_APPLY) |=> (state_w == ST_IDLE));

endmodule

bind cap_trim_combiner trim_combiner_chk #(
    .CODE_W   (CODE_W),
    .TEMP_W   (TEMP_W),
    .CODE_MIN (CODE_MIN),
    .CODE_MAX (CODE_MAX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .eng_done       (eng_done),
    .eng_temp       (eng_temp),
    .trim_code      (trim_code),
    .conv_busy      (conv_busy),
    .state_w        (state_w),
    .pend_w         (pend_w),
    .temp_changed_w (temp_changed_w)
);

// File: tb/sim_cap_trim_combiner.sv
module sim_cap_trim_combiner;

    localparam int CW   = 6;
    localparam int TW   = 4;
    localparam int CMIN = 2;
    localparam int CMAX = 60;
    localparam int TRST = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] eng_code = '0;
    logic          eng_done = 1'b0;
    logic [TW-1:0] eng_temp = '0;
    logic          manual_req = 1'b0;
    logic          ofs_wr_en = 1'b0;
    logic [7:0]    ofs_wr_data = '0;
    logic [CW-1:0] trim_code;
    logic          conv_busy;

    int total = 0;
    int bad = 0;
    bit done_flag = 1'b0;
    int last_exp = TRST;
    logic [TW-1:0] cur_temp = '0;

    always #10 clk = ~clk;

    cap_trim_combiner #(
        .CODE_W(CW), .TEMP_W(TW), .CODE_MIN(CMIN), .CODE_MAX(CMAX), .TRIM_RST(TRST)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .eng_code(eng_code), .eng_done(eng_done),
        .eng_temp(eng_temp), .manual_req(manual_req), .ofs_wr_en(ofs_wr_en),
        .ofs_wr_data(ofs_wr_data), .trim_code(trim_code), .conv_busy(conv_busy)
    );

    function automatic int model(input int code, input int ofs8);
        int s;
        s = code + ((ofs8 >= 128) ? ofs8 - 256 : ofs8);
        if (s < CMIN) s = CMIN;
        if (s > CMAX) s = CMAX;
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ofs(input int v);
        @(negedge clk);
        ofs_wr_en = 1'b1;
        ofs_wr_data = 8'(v);
        @(negedge clk);
        ofs_wr_en = 1'b0;
        @(negedge clk);
        check("R4", int'(trim_code), last_exp);
    endtask

    // strobe at one negedge; result sampled three negedges later
    task automatic strobe(input int code, input logic [TW-1:0] t, output int mid_busy);
        @(negedge clk);
        eng_code = CW'(code);
        eng_temp = t;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        @(negedge clk);
        mid_busy = int'(conv_busy);
        @(negedge clk);
    endtask

    initial begin
        int mb;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", int'(trim_code), TRST);
        check("R1", int'(conv_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 first strobe after reset accepted even with temperature 0; R1 offset 0
        strobe(10, 4'd0, mb);
        check("R5", mb, 1);
        check("R1", int'(trim_code), 10);
        check("R6", int'(conv_busy), 0);
        last_exp = 10;

        // R6 same temperature dropped
        strobe(20, 4'd0, mb);
        check("R6", int'(trim_code), 10);
        check("R6", mb, 0);

        // R7 manual request forces same-temperature conversion
        @(negedge clk);
        manual_req = 1'b1;
        @(negedge clk);
        manual_req = 1'b0;
        check("R7", int'(conv_busy), 1);
        repeat (4) @(negedge clk);
        check("R8", int'(conv_busy), 1);
        check("R7", int'(trim_code), 10);
        strobe(20, 4'd0, mb);
        check("R7", int'(trim_code), 20);
        check("R7", int'(conv_busy), 0);
        last_exp = 20;

        // R9 strobe held during SUM is ignored
        @(negedge clk);
        eng_code = 6'd30; eng_temp = 4'd5; eng_done = 1'b1;
        @(negedge clk);
        eng_code = 6'd45; eng_temp = 4'd9;
        @(negedge clk);
        eng_done = 1'b0;
        @(negedge clk);
        check("R9", int'(trim_code), 30);
        repeat (4) @(negedge clk);
        check("R9", int'(trim_code), 30);
        check("R9", int'(conv_busy), 0);
        last_exp = 30;
        cur_temp = 4'd5;

        // exhaustive sweep: every correction byte against every code (R2, R3, R4, R5)
        for (int ofs = 0; ofs < 256; ofs++) begin
            write_ofs(ofs);
            for (int code = 0; code < 64; code++) begin
                int e;
                cur_temp = cur_temp ^ 4'd1;
                strobe(code, cur_temp, mb);
                e = model(code, ofs);
                if (e == CMIN || e == CMAX) check("R3", int'(trim_code), e);
                else check("R2", int'(trim_code), e);
                check("R5", mb, 1);
                last_exp = e;
            end
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done_flag) begin
            done_flag = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule